// File: doc/BRIEF.md
# Fracturable Logic Element with Scan Readback

This block is one logic element of a small programmable fabric. A 16-entry truth table serves either as one 4-input function or as two 3-input functions that share the three low inputs. Two D flip-flops sit behind the table. A static mode field chooses how the table and the registers are used: one function feeding one register, two functions each feeding its own register, or a 2-bit shift register that takes its serial data from one table input.

For test, a scan path runs through both flip-flops. While the test enable is high, the registers stop following the table and shift instead: the scan input enters the first register, the first register moves into the second, and the second register appears on the scan output. Elements can be chained through their scan pins so that a controller can read every register out serially. Each of the two data outputs has its own configuration bit that picks either the register or the combinational value.

Top module: `frac_logic_elem`

## Requirements
- R1: A synchronous active-high `rst` clears both flip-flops to 0 at the next rising edge, and it takes priority over `test_en` and every mode.
- R2: Mode 2'b00 (single): the combinational value of both outputs is truth-table bit `cfg_truth[lut_in]`, where `lut_in` is read as an unsigned index 0..15.
- R3: In single mode with `test_en` low, flip-flop 0 captures the 4-input function at each rising edge and flip-flop 1 keeps its value.
- R4: Mode 2'b01 (dual): output 0's combinational value is `cfg_truth[lut_in[2:0]]` (lower 8 bits), output 1's is `cfg_truth[8 + lut_in[2:0]]` (upper 8 bits); `lut_in[3]` has no effect on either.
- R5: In dual mode with `test_en` low, flip-flop 0 captures the lower-half function and flip-flop 1 the upper-half function at each rising edge.
- R6: Mode 2'b10 (shift): with `test_en` low, flip-flop 0 loads `lut_in[0]` and flip-flop 1 loads the old flip-flop 0; `data_out[0]` shows flip-flop 0 and `data_out[1]` shows flip-flop 1 whatever `cfg_out_reg` holds.
- R7: With `test_en` high (and `rst` low), in every mode flip-flop 0 loads `scan_in` and flip-flop 1 loads the old flip-flop 0; the table does not reach the registers.
- R8: `scan_out` always equals flip-flop 1.
- R9: Outside shift mode, `cfg_out_reg[n]` = 1 makes `data_out[n]` show flip-flop n and 0 makes it show the combinational value of output n.
- R10: Mode 2'b11 behaves exactly as single mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of both flip-flops |
| cfg_truth | input | 16 | Truth-table bits, index = LUT input value |
| cfg_mode | input | 2 | 00 single, 01 dual, 10 shift, 11 as single |
| cfg_out_reg | input | 2 | Per output: 1 registered, 0 combinational |
| lut_in | input | 4 | Table inputs; bit 0 is serial data in shift mode |
| test_en | input | 1 | Scan shift enable |
| scan_in | input | 1 | Serial scan input into flip-flop 0 |
| data_out | output | 2 | Element outputs |
| scan_out | output | 1 | Serial scan output (flip-flop 1) |

## Verification
The bench targets the split between the halves: a design that fed `lut_in[3]` into the 3-input functions, or swapped the halves, shows wrong combinational values in dual mode. It checks that flip-flop 1 holds in single mode rather than loading zero or the table, that the scan and shift paths move data in the right direction rather than reversing it, and that test enable overrides the table while reset overrides test enable. It also checks that shift mode ignores the output select bits and that the reserved mode code is decoded as single mode rather than as dual or shift.

// File: rtl/fle_pkg.sv
package fle_pkg;
   typedef enum logic [1:0] {
      MODE_SINGLE = 2'b00,
      MODE_DUAL   = 2'b01,
      MODE_SHIFT  = 2'b10,
      MODE_RSVD   = 2'b11
   } fle_mode_e;

   function automatic logic is_single(input fle_mode_e m);
      return (m == MODE_SINGLE) || (m == MODE_RSVD);
   endfunction
endpackage

// File: rtl/fle_lut.sv
module fle_lut #(
   parameter int LUT_K = 4,
   localparam int ENTRIES = 1 << LUT_K,
   localparam int SUB_K = LUT_K - 1
) (
   input  logic [ENTRIES-1:0] truth,
   input  logic [LUT_K-1:0]   sel,
   output logic               f_full,
   output logic               f_lo,
   output logic               f_hi
);
   generate
      if (LUT_K < 2) begin : g_bad_k
         $error("fle_lut: LUT_K must be at least 2");
      end
   endgenerate

   logic [SUB_K-1:0] sub_sel;

   always_comb begin
      sub_sel = sel[SUB_K-1:0];
      f_full  = truth[sel];
      f_lo    = truth[{1'b0, sub_sel}];
      f_hi    = truth[{1'b1, sub_sel}];
   end
endmodule

// File: rtl/fle_ff_pair.sv
module fle_ff_pair
   import fle_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  fle_mode_e mode,
   input  logic      test_en,
   input  logic      scan_in,
   input  logic      sr_din,
   input  logic      f_full,
   input  logic      f_lo,
   input  logic      f_hi,
   output logic [1:0] q
);
   logic [1:0] q_nxt;

   always_comb begin
      q_nxt = q;
      if (test_en) begin
         q_nxt = {q[0], scan_in};
      end else begin
         unique case (mode)
            MODE_DUAL:  q_nxt = {f_hi, f_lo};
            MODE_SHIFT: q_nxt = {q[0], sr_din};
            default:    q_nxt = {q[1], f_full};
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= q_nxt;
   end

   a_r1_reset_clears: assert property (@(posedge clk) rst |=> (q == 2'b00));
   a_r7_scan_shift: assert property (@(posedge clk) disable iff (rst)
      test_en |=> (q[0] == $past(scan_in)) && (q[1] == $past(q[0])));
   a_r6_serial_shift: assert property (@(posedge clk) disable iff (rst)
      (!test_en && mode == MODE_SHIFT) |=> (q[0] == $past(sr_din)) && (q[1] == $past(q[0])));
   a_r3_hold_ff1: assert property (@(posedge clk) disable iff (rst)
      (!test_en && is_single(mode)) |=> (q[1] == $past(q[1])) && (q[0] == $past(f_full)));
   a_r5_dual_capture: assert property (@(posedge clk) disable iff (rst)
      (!test_en && mode == MODE_DUAL) |=> (q == $past({f_hi, f_lo})));
endmodule

// File: rtl/fle_out_mux.sv
module fle_out_mux
   import fle_pkg::*;
#(
   parameter int N_OUT = 2
) (
   input  fle_mode_e        mode,
   input  logic [N_OUT-1:0] reg_sel,
   input  logic             f_full,
   input  logic             f_lo,
   input  logic             f_hi,
   input  logic [N_OUT-1:0] q,
   output logic [N_OUT-1:0] dout
);
   generate
      if (N_OUT != 2) begin : g_bad_n
         $error("fle_out_mux: the element has exactly two outputs");
      end
   endgenerate

   logic [N_OUT-1:0] comb_v;

   always_comb begin
      comb_v = {f_hi, f_lo};
      if (is_single(mode)) comb_v = {N_OUT{f_full}};
   end

   for (genvar i = 0; i < N_OUT; i++) begin : g_out
      always_comb begin
         if (mode == MODE_SHIFT) dout[i] = q[i];
         else if (reg_sel[i])    dout[i] = q[i];
         else                    dout[i] = comb_v[i];
      end
   end

   always_comb begin
      a_r6_shift_regs_out: assert (mode != MODE_SHIFT || dout == q);
   end
endmodule

// File: rtl/frac_logic_elem.sv
module frac_logic_elem
   import fle_pkg::*;
#(
   parameter int LUT_K = 4,
   parameter int SR_DIN_IDX = 0,
   localparam int ENTRIES = 1 << LUT_K,
   localparam int N_OUT = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [ENTRIES-1:0] cfg_truth,
   input  logic [1:0]         cfg_mode,
   input  logic [N_OUT-1:0]   cfg_out_reg,
   input  logic [LUT_K-1:0]   lut_in,
   input  logic               test_en,
   input  logic               scan_in,
   output logic [N_OUT-1:0]   data_out,
   output logic               scan_out
);
   generate
      if (SR_DIN_IDX < 0 || SR_DIN_IDX >= LUT_K) begin : g_bad_idx
         $error("frac_logic_elem: SR_DIN_IDX outside LUT inputs");
      end
   endgenerate

   fle_mode_e  mode;
   logic       f_full, f_lo, f_hi;
   logic [1:0] q;

   assign mode = fle_mode_e'(cfg_mode);

   fle_lut #(.LUT_K(LUT_K)) u_lut (
      .truth (cfg_truth),
      .sel   (lut_in),
      .f_full(f_full),
      .f_lo  (f_lo),
      .f_hi  (f_hi)
   );

   fle_ff_pair u_ffs (
      .clk    (clk),
      .rst    (rst),
      .mode   (mode),
      .test_en(test_en),
      .scan_in(scan_in),
      .sr_din (lut_in[SR_DIN_IDX]),
      .f_full (f_full),
      .f_lo   (f_lo),
      .f_hi   (f_hi),
      .q      (q)
   );

   fle_out_mux #(.N_OUT(N_OUT)) u_mux (
      .mode   (mode),
      .reg_sel(cfg_out_reg),
      .f_full (f_full),
      .f_lo   (f_lo),
      .f_hi   (f_hi),
      .q      (q),
      .dout   (data_out)
   );

   assign scan_out = q[1];

   a_r8_scan_out_follows: assert property (@(posedge clk) disable iff (rst)
      test_en |=> (scan_out == $past(q[0])));
   a_r9_comb_select: assert property (@(posedge clk) disable iff (rst)
      (is_single(mode) && !cfg_out_reg[0]) |-> (data_out[0] == cfg_truth[lut_in]));
endmodule

// File: tb/frac_logic_elem_bench.sv
module frac_logic_elem_bench;
   logic        clk = 1'b0;
   logic        rst;
   logic [15:0] cfg_truth;
   logic [1:0]  cfg_mode;
   logic [1:0]  cfg_out_reg;
   logic [3:0]  lut_in;
   logic        test_en;
   logic        scan_in;
   logic [1:0]  data_out;
   logic        scan_out;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  done = 0;
   bit  mvalid = 0;
   int  m0 = 0;
   int  m1 = 0;

   always #5 clk = ~clk;

   frac_logic_elem u_frac_logic_elem (
      .clk(clk), .rst(rst), .cfg_truth(cfg_truth), .cfg_mode(cfg_mode),
      .cfg_out_reg(cfg_out_reg), .lut_in(lut_in), .test_en(test_en),
      .scan_in(scan_in), .data_out(data_out), .scan_out(scan_out)
   );

   function automatic int tbit(input logic [15:0] t, input int idx);
      return int'((t >> idx) & 16'd1);
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d (mode %0d lut_in %0d)",
                  tag, act, exp, cfg_mode, lut_in);
      end
   endtask

   task automatic step(input logic [15:0] t, input logic [1:0] m, input logic [1:0] s,
                       input logic [3:0] li, input logic te, input logic si,
                       input logic r, input string rtag);
      int idx, lo3, comb0, comb1, e0, e1;
      @(negedge clk);
      cfg_truth = t; cfg_mode = m; cfg_out_reg = s; lut_in = li;
      test_en = te; scan_in = si; rst = r;
      #1;
      idx = int'(li);
      lo3 = idx % 8;
      if (m == 2'b01) begin
         comb0 = tbit(t, lo3);
         comb1 = tbit(t, 8 + lo3);
      end else begin
         comb0 = tbit(t, idx);
         comb1 = comb0;
      end
      if (mvalid) begin
         if (m == 2'b10) begin
            check("R6 out0", int'(data_out[0]), m0);
            check("R6 out1", int'(data_out[1]), m1);
         end else begin
            e0 = s[0] ? m0 : comb0;
            e1 = s[1] ? m1 : comb1;
            check(s[0] ? {"R9 reg out0 ", rtag} : (m == 2'b01 ? "R4 out0" : "R2 out0"),
                  int'(data_out[0]), e0);
            check(s[1] ? {"R9 reg out1 ", rtag} : (m == 2'b01 ? "R4 out1" : "R2 out1"),
                  int'(data_out[1]), e1);
         end
         check({"R8 scan_out ", rtag}, int'(scan_out), m1);
      end
      @(posedge clk);
      if (r) begin
         m0 = 0; m1 = 0; mvalid = 1;
      end else if (te) begin
         m1 = m0; m0 = int'(si);
      end else if (m == 2'b01) begin
         m0 = comb0; m1 = comb1;
      end else if (m == 2'b10) begin
         m1 = m0; m0 = idx % 2;
      end else begin
         m0 = comb0;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      #1500000;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] tt;
      rst = 1; test_en = 0; scan_in = 0; cfg_truth = 0; cfg_mode = 0;
      cfg_out_reg = 0; lut_in = 0;
      step(16'h0000, 2'b00, 2'b11, 4'h0, 1'b0, 1'b0, 1'b1, "R1");
      // R1: reset state visible on registered outputs and scan_out
      step(16'hFFFF, 2'b00, 2'b11, 4'hF, 1'b0, 1'b0, 1'b1, "R1");
      step(16'hFFFF, 2'b00, 2'b11, 4'hF, 1'b0, 1'b0, 1'b0, "R1");
      // R2: single mode, every index, combinational
      for (int i = 0; i < 16; i++)
         step(16'hA5C3, 2'b00, 2'b00, 4'(i), 1'b0, 1'b0, 1'b0, "R2");
      // R3: single registered, ff1 holds
      for (int i = 0; i < 16; i++)
         step(16'h6B1E, 2'b00, 2'b11, 4'(i), 1'b0, 1'b0, 1'b0, "R3");
      // R4 / R5: dual mode, lut_in[3] must not matter
      for (int i = 0; i < 16; i++)
         step(16'h3C96, 2'b01, 2'b00, 4'(i), 1'b0, 1'b0, 1'b0, "R4");
      for (int i = 0; i < 16; i++)
         step(16'hF00D, 2'b01, 2'b11, 4'(i), 1'b0, 1'b0, 1'b0, "R5");
      // R6: shift mode with select bits cleared
      for (int i = 0; i < 12; i++)
         step(16'hFFFF, 2'b10, 2'b00, 4'((i * 5) % 16), 1'b0, 1'b0, 1'b0, "R6");
      // R7: scan shifting in every mode
      for (int i = 0; i < 16; i++)
         step(16'hFFFF, 2'(i % 4), 2'b11, 4'hF, 1'b1, 1'((i * 3) % 2 ^ (i / 3) % 2),
              1'b0, "R7");
      // R1: reset beats test enable
      step(16'hFFFF, 2'b01, 2'b11, 4'hF, 1'b1, 1'b1, 1'b1, "R1");
      step(16'hFFFF, 2'b01, 2'b11, 4'hF, 1'b1, 1'b1, 1'b0, "R1");
      // R10: reserved code behaves as single
      for (int i = 0; i < 16; i++)
         step(16'h9E37, 2'b11, 2'(i % 4), 4'(15 - i), 1'b0, 1'b0, 1'b0, "R10");
      // mixed random traffic
      for (int i = 0; i < 3000; i++) begin
         tt = 16'($urandom);
         step(tt, 2'($urandom), 2'($urandom), 4'($urandom),
              1'(($urandom % 4) == 0), 1'($urandom), 1'(($urandom % 50) == 0), "R9");
      end
      finish_run();
   end
endmodule